// File: doc/BRIEF.md
# Scratchpad Staging Buffer with Target-Address and Status Registers

This block is a 64-byte staging buffer that sits between a single-wire byte transport and a non-volatile array. It keeps a 16-bit target address, packs an 8-bit status byte, and runs two command sequences over a received-byte stream. The write sequence fills the buffer from the low six bits of the target address. The read sequence streams back the address, the status and the buffered data. Both sequences fold every byte into a 16-bit CRC and return its ones' complement, so the host can confirm the transfer.

A transport layer above the block delivers whole or partial bytes on `rx_*`. It asks for a transmit byte with `tx_req` and signals a bus reset with `bus_rst`. Every command starts with the first byte received after a bus reset. A separate copy engine reads the target address, the status and any buffered byte through the `cp_*` port, and reports a finished transfer with `cp_aa_set`. The block does not move data into the non-volatile array itself.

Top module: `sp_scratchpad`

## Requirements
- R1: After the synchronous reset, `cp_es` is 40h (PF=1, AA=0, ending offset 0), `cp_ta` is 0 and `tx_valid` is 0.
- R2: Command 0Fh accepts the address low byte and then the high byte. Bit 15 of the stored address is forced to 0. Loading the address clears PF (status bit 6) and AA (status bit 7). The data bytes that follow are stored at consecutive offsets, starting at address bits 5:0.
- R3: The status bits 5:0 hold the offset of the last full byte stored. After the byte at offset 3Fh, further received bytes are neither stored nor counted, and the status stays at 3Fh.
- R4: A partial byte in the data phase is discarded and sets PF. All later bytes of that command are ignored.
- R5: For an address in 7FC0h–7FCFh, address bits 2:0 are forced to 0. While the offset is below 10h, the ending offset is updated only when the byte at an offset whose low three bits are 111b is stored.
- R6: During a write command, each `tx_req` returns FFh until offset 3Fh has been written. After that, the requests return the low byte and then the high byte of the inverted CRC, and FFh afterwards.
- R7: Command AAh answers successive `tx_req` with address low, address high, status, the data from the start offset to 3Fh, the inverted CRC low byte, the inverted CRC high byte, and then FFh until a bus reset. Each answer appears on `tx_byte`, with `tx_valid` high, in the cycle after the request.
- R8: The CRC uses the reflected polynomial x^16+x^15+x^2+1 (A001h), LSB first, and starts from 0. A write covers the command byte, both address bytes as received, and the stored data. A read covers the command byte, the stored address bytes, the status and the data sent.
- R9: `bus_rst` ends the current command and leaves the address and the stored data unchanged. A byte offered in the same cycle is dropped. The next byte is decoded as a command.
- R10: `cp_ta`/`cp_es` mirror the registers, and `cp_rd_data` returns the buffered byte at `cp_rd_addr` in the same cycle. `cp_aa_set` sets AA, but an address-high load in the same cycle clears it.
- R11: Any other command byte makes the block ignore all received bytes and answer FFh until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Bus reset pulse; aborts the command in progress |
| rx_valid | input | 1 | A received byte is offered |
| rx_byte | input | 8 | Received byte, LSB first on the wire |
| rx_partial | input | 1 | The offered byte had fewer than 8 bits |
| tx_req | input | 1 | Request for the next transmit byte |
| tx_valid | output | 1 | Transmit byte is valid (one cycle after `tx_req`) |
| tx_byte | output | 8 | Transmit byte |
| cp_ta | output | 16 | Stored target address |
| cp_es | output | 8 | Status: AA bit 7, PF bit 6, ending offset bits 5:0 |
| cp_aa_set | input | 1 | Copy finished; sets AA |
| cp_rd_addr | input | 6 | Buffer offset read by the copy engine |
| cp_rd_data | output | 8 | Buffered byte at `cp_rd_addr` |

## Verification
The sharpest same-cycle collision is a bus reset arriving while a data byte is being offered during the write phase. The reset must win: the byte is not stored, and the next byte is taken as a command. The bench provokes this by raising `bus_rst` and `rx_valid` in the same cycle in the middle of a write. It then judges the result in three ways. It reads the offset that byte would have hit through the copy port. It checks that the ending offset has not moved. It starts a read command at once and checks that the address comes back. A second collision, an AA set against an address-high load, is provoked and judged the same way through `cp_es`.

// File: rtl/sp_pkg.sv
// Shared types and CRC arithmetic for the scratchpad block.
// Assumes byte-wide transport and a 16-bit reflected CRC.
package sp_pkg;

    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [2:0] {
        S_CMD, S_TA1, S_TA2, S_WDAT, S_WEND, S_RD, S_HALT
    } sp_state_t;

    typedef enum logic [2:0] {
        P_TA1, P_TA2, P_ES, P_DAT, P_CRC0, P_CRC1, P_ONES
    } sp_phase_t;

    // Advance the CRC by one byte, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            r = (r[0] ^ d[k]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/sp_crc.sv
// Running CRC16 accumulator.
// clr restarts from zero; when en is also high, din is folded into the zero state.
module sp_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import sp_pkg::*;

    // Update the CRC register on a clear or data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          crc <= '0;
        else if (en)         crc <= crc16_step(clr ? 16'h0000 : crc, din);
        else if (clr)        crc <= '0;
    end
endmodule

// File: rtl/sp_store.sv
// Byte storage for the scratchpad: one synchronous write port and two
// asynchronous read ports (command engine and copy engine). No reset on contents.
module sp_store #(
    parameter int OFF_W = 6,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [OFF_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [OFF_W-1:0] raddr_a,
    output logic [DW-1:0]    rdata_a,
    input  logic [OFF_W-1:0] raddr_b,
    output logic [DW-1:0]    rdata_b
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DW-1:0] mem [DEPTH];

    // Store a byte on write enable.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read both ports combinationally.
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end
endmodule

// File: rtl/sp_scratchpad.sv
// Scratchpad controller: decodes the write (CMD_WRITE) and read (CMD_READ)
// command sequences, keeps the target address and status byte, and exposes
// them to a copy engine. Assumes the first received byte after bus_rst is
// a command and that the status byte packs AA, PF and a 6-bit offset.
module sp_scratchpad #(
    parameter logic [7:0]  CMD_WRITE = 8'h0F,
    parameter logic [7:0]  CMD_READ  = 8'hAA,
    parameter logic [15:0] PW_BASE   = 16'h7FC0,
    parameter int          PW_SPAN_W = 4,
    parameter int          PW_GRP_W  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_partial,
    input  logic        tx_req,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic [15:0] cp_ta,
    output logic [7:0]  cp_es,
    input  logic        cp_aa_set,
    input  logic [5:0]  cp_rd_addr,
    output logic [7:0]  cp_rd_data
);
    import sp_pkg::*;

    localparam int                ADDR_W  = 16;
    localparam int                OFF_W   = 6;
    localparam logic [OFF_W-1:0]  OFF_MAX = '1;

    sp_state_t         state;
    sp_phase_t         ph;
    logic [ADDR_W-1:0] ta;
    logic              aa, pf, pwm;
    logic [OFF_W-1:0]  eoff, off;
    logic [15:0]       crc;
    logic              mem_we, crc_clr, crc_en;
    logic [7:0]        crc_din, tx_next, rd_a, es;
    logic [ADDR_W-1:0] addr_in, addr_fix;
    logic              pw_hit, grp_mode;

    assign es    = {aa, pf, eoff};
    assign cp_es = es;
    assign cp_ta = ta;

    // Shape the incoming address: clear the top bit, align password targets.
    always_comb begin
        addr_in             = {rx_byte, ta[7:0]};
        addr_in[ADDR_W-1]   = 1'b0;
        pw_hit              = addr_in[ADDR_W-1:PW_SPAN_W] == PW_BASE[ADDR_W-1:PW_SPAN_W];
        addr_fix            = addr_in;
        if (pw_hit) addr_fix[PW_GRP_W-1:0] = '0;
        grp_mode            = pwm && (off[OFF_W-1:PW_SPAN_W] == '0);
    end

    // Decide storage, CRC and transmit actions for this cycle.
    always_comb begin
        mem_we  = 1'b0;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        crc_din = rx_byte;
        tx_next = 8'hFF;
        if (!bus_rst) begin
            case (state)
                S_CMD:  if (rx_valid && !rx_partial) begin crc_clr = 1'b1; crc_en = 1'b1; end
                S_TA1,
                S_TA2:  if (rx_valid && !rx_partial) crc_en = 1'b1;
                S_WDAT: if (rx_valid && !rx_partial) begin mem_we = 1'b1; crc_en = 1'b1; end
                S_WEND, S_RD: if (tx_req) begin
                    case (ph)
                        P_TA1:   tx_next = ta[7:0];
                        P_TA2:   tx_next = ta[15:8];
                        P_ES:    tx_next = es;
                        P_DAT:   tx_next = rd_a;
                        P_CRC0:  tx_next = ~crc[7:0];
                        P_CRC1:  tx_next = ~crc[15:8];
                        default: tx_next = 8'hFF;
                    endcase
                    crc_din = tx_next;
                    crc_en  = (state == S_RD) &&
                              (ph == P_TA1 || ph == P_TA2 || ph == P_ES || ph == P_DAT);
                end
                default: ;
            endcase
        end
    end

    // Sequence commands and hold address, status and pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_CMD;  ph <= P_TA1;  ta <= '0;  aa <= 1'b0;  pf <= 1'b1;
            pwm <= 1'b0;  eoff <= '0;  off <= '0;  tx_valid <= 1'b0;  tx_byte <= 8'hFF;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) tx_byte <= tx_next;
            if (cp_aa_set) aa <= 1'b1;
            if (bus_rst) begin
                state <= S_CMD;
            end else begin
                case (state)
                    S_CMD: if (rx_valid) begin
                        ph <= P_TA1;
                        if (rx_partial)               state <= S_HALT;
                        else if (rx_byte == CMD_WRITE) state <= S_TA1;
                        else if (rx_byte == CMD_READ)  state <= S_RD;
                        else                           state <= S_HALT;
                    end
                    S_TA1: if (rx_valid) begin
                        if (rx_partial) state <= S_HALT;
                        else begin ta[7:0] <= rx_byte; state <= S_TA2; end
                    end
                    S_TA2: if (rx_valid) begin
                        if (rx_partial) state <= S_HALT;
                        else begin
                            ta <= addr_fix;  off <= addr_fix[OFF_W-1:0];  pwm <= pw_hit;
                            aa <= 1'b0;  pf <= 1'b0;  state <= S_WDAT;
                        end
                    end
                    S_WDAT: if (rx_valid) begin
                        if (rx_partial) begin pf <= 1'b1; state <= S_HALT; end
                        else begin
                            if (!grp_mode || (&off[PW_GRP_W-1:0])) eoff <= off;
                            off <= off + 1'b1;
                            if (off == OFF_MAX) begin state <= S_WEND; ph <= P_CRC0; end
                        end
                    end
                    S_WEND, S_RD: if (tx_req) begin
                        case (ph)
                            P_TA1:  ph <= P_TA2;
                            P_TA2:  ph <= P_ES;
                            P_ES:   begin off <= ta[OFF_W-1:0]; ph <= P_DAT; end
                            P_DAT:  begin off <= off + 1'b1; if (off == OFF_MAX) ph <= P_CRC0; end
                            P_CRC0: ph <= P_CRC1;
                            default: ph <= P_ONES;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    sp_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc)
    );

    sp_store #(.OFF_W(OFF_W), .DW(8)) u_store (
        .clk(clk), .we(mem_we), .waddr(off), .wdata(rx_byte),
        .raddr_a(off), .rdata_a(rd_a), .raddr_b(cp_rd_addr), .rdata_b(cp_rd_data)
    );
endmodule

// File: rtl/sp_scratchpad_chk.sv
// Port-level temporal checks for sp_scratchpad, attached by bind.
module sp_scratchpad_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rst,
    input logic        rx_valid,
    input logic        rx_partial,
    input logic        tx_req,
    input logic        tx_valid,
    input logic [15:0] cp_ta,
    input logic [7:0]  cp_es,
    input logic        cp_aa_set
);
    // R7
    tx_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R4
    pf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_es[6]) |-> $past(rx_valid && rx_partial));

    // R10
    aa_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_es[7]) |-> $past(cp_aa_set));

    // R9
    bus_rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rst) |-> (cp_ta == $past(cp_ta)));

    // R3
    eoff_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_es[5:0] != $past(cp_es[5:0])) |-> $past(rx_valid));
endmodule

bind sp_scratchpad sp_scratchpad_chk u_sp_chk (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .rx_partial(rx_partial), .tx_req(tx_req), .tx_valid(tx_valid),
    .cp_ta(cp_ta), .cp_es(cp_es), .cp_aa_set(cp_aa_set)
);

// File: tb/sp_scratchpad_bench.sv
// Self-checking bench: sweeps every start offset through write and read-back,
// then exercises partial bytes, password alignment, bus reset and collisions.
module sp_scratchpad_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_partial = 1'b0;
    logic        tx_req = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [15:0] cp_ta;
    logic [7:0]  cp_es;
    logic        cp_aa_set = 1'b0;
    logic [5:0]  cp_rd_addr = 6'd0;
    logic [7:0]  cp_rd_data;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [7:0]  model [64];
    logic [15:0] crc, sent, exp_ta;
    logic [7:0]  got, d;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_scratchpad u_sp_scratchpad (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_partial(rx_partial), .tx_req(tx_req),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .cp_ta(cp_ta), .cp_es(cp_es),
        .cp_aa_set(cp_aa_set), .cp_rd_addr(cp_rd_addr), .cp_rd_data(cp_rd_data)
    );

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        repeat (8) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input bit part);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_partial = part;
        @(negedge clk);
        rx_valid = 1'b0; rx_partial = 1'b0;
    endtask

    task automatic read(output logic [7:0] b);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        chk(tx_valid === 1'b1, "R7 tx_valid", 32'(tx_valid), 32'd1);
        b = tx_byte;
    endtask

    task automatic rd_chk(input logic [7:0] exp, input string req);
        logic [7:0] v;
        read(v);
        chk(v === exp, req, 32'(v), 32'(exp));
    endtask

    task automatic bus_pulse();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    task automatic cp_chk(input logic [5:0] a, input logic [7:0] exp, input string req);
        cp_rd_addr = a;
        #1;
        chk(cp_rd_data === exp, req, 32'(cp_rd_data), 32'(exp));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cp_es === 8'h40, "R1 status", 32'(cp_es), 32'h40);
        chk(cp_ta === 16'h0, "R1 address", 32'(cp_ta), 32'h0);
        chk(tx_valid === 1'b0, "R1 tx_valid", 32'(tx_valid), 32'h0);

        // R2 R3 R6 R7 R8: sweep every start offset, ascending so storage gets defined
        for (int o = 0; o < 64; o++) begin
            sent = 16'(((o * 37 + 5) % 500) * 64 + o);
            if (o % 2 == 1) sent[15] = 1'b1;
            exp_ta = sent & 16'h7FFF;
            bus_pulse();
            crc = crc_add(16'h0, 8'h0F);
            send(8'h0F, 1'b0);
            send(sent[7:0], 1'b0);  crc = crc_add(crc, sent[7:0]);
            send(sent[15:8], 1'b0); crc = crc_add(crc, sent[15:8]);
            for (int i = o; i < 64; i++) begin
                d = 8'(i * 7 + o * 29 + 3);
                model[i] = d;
                send(d, 1'b0);
                crc = crc_add(crc, d);
            end
            send(8'hC3, 1'b0);
            send(8'h3C, 1'b0);
            chk(cp_es === 8'h3F, "R3 ending offset full", 32'(cp_es), 32'h3F);
            chk(cp_ta === exp_ta, "R2 address top bit", 32'(cp_ta), 32'(exp_ta));
            rd_chk(~crc[7:0], "R6 R8 write crc low");
            rd_chk(~crc[15:8], "R6 R8 write crc high");
            rd_chk(8'hFF, "R6 after crc");
            bus_pulse();
            send(8'hAA, 1'b0);
            crc = crc_add(16'h0, 8'hAA);
            rd_chk(exp_ta[7:0], "R7 addr low");  crc = crc_add(crc, exp_ta[7:0]);
            rd_chk(exp_ta[15:8], "R7 addr high"); crc = crc_add(crc, exp_ta[15:8]);
            rd_chk(8'h3F, "R7 status");           crc = crc_add(crc, 8'h3F);
            for (int i = o; i < 64; i++) begin
                rd_chk(model[i], "R7 R3 data");
                crc = crc_add(crc, model[i]);
            end
            rd_chk(~crc[7:0], "R7 R8 read crc low");
            rd_chk(~crc[15:8], "R7 R8 read crc high");
            rd_chk(8'hFF, "R7 ones");
            rd_chk(8'hFF, "R7 ones again");
        end

        // R10 copy port reads every buffered byte
        for (int a = 0; a < 64; a++) cp_chk(6'(a), model[a], "R10 copy read");

        // R6 before the buffer is full the write command answers FFh
        bus_pulse();
        send(8'h0F, 1'b0); send(8'h00, 1'b0); send(8'h02, 1'b0);
        send(8'h11, 1'b0); model[0] = 8'h11;
        rd_chk(8'hFF, "R6 not full");
        chk(cp_es === 8'h00, "R2 status cleared", 32'(cp_es), 32'h00);

        // R5 password address alignment and whole-group ending offset
        bus_pulse();
        send(8'h0F, 1'b0); send(8'hC5, 1'b0); send(8'h7F, 1'b0);
        chk(cp_ta === 16'h7FC0, "R5 aligned address", 32'(cp_ta), 32'h7FC0);
        for (int i = 0; i < 16; i++) begin
            d = 8'(8'h50 + i);
            model[i] = d;
            send(d, 1'b0);
            if (i == 4)  chk(cp_es === 8'h00, "R5 no update mid group", 32'(cp_es), 32'h00);
            if (i == 7)  chk(cp_es === 8'h07, "R5 first group", 32'(cp_es), 32'h07);
            if (i == 10) chk(cp_es === 8'h07, "R5 incomplete group", 32'(cp_es), 32'h07);
            if (i == 15) chk(cp_es === 8'h0F, "R5 second group", 32'(cp_es), 32'h0F);
        end

        // R10 copy engine sets AA
        @(negedge clk); cp_aa_set = 1'b1;
        @(negedge clk); cp_aa_set = 1'b0;
        chk(cp_es === 8'h8F, "R10 AA set", 32'(cp_es), 32'h8F);

        // R10 AA set collides with address-high load: clear wins
        bus_pulse();
        send(8'h0F, 1'b0); send(8'h05, 1'b0);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h00; cp_aa_set = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; cp_aa_set = 1'b0;
        chk(cp_es === 8'h0F, "R10 AA cleared on load", 32'(cp_es), 32'h0F);
        chk(cp_ta === 16'h0005, "R2 address load", 32'(cp_ta), 32'h0005);

        // R4 partial byte sets PF and ends the data phase
        send(8'hA1, 1'b0); model[5] = 8'hA1;
        send(8'hA2, 1'b0); model[6] = 8'hA2;
        send(8'hA3, 1'b0); model[7] = 8'hA3;
        send(8'hEE, 1'b1);
        send(8'h77, 1'b0);
        chk(cp_es === 8'h47, "R4 PF and offset", 32'(cp_es), 32'h47);
        cp_chk(6'd8, model[8], "R4 no store after partial");
        cp_chk(6'd7, 8'hA3, "R4 last full byte");

        // R9 bus reset with a same-cycle byte: reset wins
        bus_pulse();
        send(8'h0F, 1'b0); send(8'h20, 1'b0); send(8'h01, 1'b0);
        send(8'hB0, 1'b0); model[32] = 8'hB0;
        send(8'hB1, 1'b0); model[33] = 8'hB1;
        @(negedge clk);
        bus_rst = 1'b1; rx_valid = 1'b1; rx_byte = 8'h99;
        @(negedge clk);
        bus_rst = 1'b0; rx_valid = 1'b0;
        cp_chk(6'd34, model[34], "R9 dropped byte");
        chk(cp_es === 8'h21, "R9 offset kept", 32'(cp_es), 32'h21);
        send(8'hAA, 1'b0);
        rd_chk(8'h20, "R9 next byte is command");
        chk(cp_ta === 16'h0120, "R9 address kept", 32'(cp_ta), 32'h0120);

        // R11 unknown command ignores everything until bus reset
        bus_pulse();
        send(8'h55, 1'b0);
        send(8'h0F, 1'b0); send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'h12, 1'b0);
        chk(cp_ta === 16'h0120, "R11 address untouched", 32'(cp_ta), 32'h0120);
        cp_chk(6'd0, model[0], "R11 data untouched");
        rd_chk(8'hFF, "R11 answers ones");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule